// File: doc/BRIEF.md
# GPIO Controller with Alternate-Function Takeover

This block manages three 4-bit bidirectional pin groups from a 4-bit register bus. Each group has three registers: a per-pin direction bit, a per-pin pull-up enable bit and a data latch. For every pin the block drives three outputs to the pad ring: output enable, output value and pull-up enable. Reading a data register returns the synchronized pin level for pins in input mode and the latched value for pins in output mode.

Two function-select bits let other peripherals take pins over. One bit gives the top two pins of group 2 to an LCD sync/frame signal pair. A serial-enable bit gives group 1 to a serial interface. Which pins it takes, and in which direction, depends on the master/slave mode reported by the serial block. A pin that is taken over keeps its group registers readable and writable, but they no longer drive it. The one exception is a pin taken as a serial input: its pull-up bit still controls its pull-up. A write to a trigger bit in the serial control register sends a one-cycle start pulse to the serial block. Reading that bit back returns the serial busy status.

Pin outputs are registered, so a register write shows at the pins after the second rising edge. Read data is also registered and appears one cycle after the address is presented.

Top module: `gpio_altfn_ctrl`

## Requirements
- R1: After reset every direction bit is 0, every pull-up bit is 1, every data bit is 0, and both select bits are 0. `pin_oe` is 0, `pin_out` is 0, and `pin_pu` equals the PU_MASK parameter.
- R2: Each group uses three registers at address 0x40 + 4·g: offset 0 holds direction, offset 1 holds pull-up and offset 2 holds data, with bit k controlling pin 4·g + k. For an ordinary pin, `pin_oe` follows the direction bit (1 = output) and `pin_out` follows the data bit. Both update after the second rising edge following the write.
- R3: For an ordinary pin, `pin_pu` is 1 only when the direction bit is 0, the pull-up bit is 1 and the PU_MASK bit is 1. A pin whose PU_MASK bit is 0 never has `pin_pu` set.
- R4: A read of a data register returns the registered `bus_rdata` one cycle after the address is presented. For an ordinary input pin the bit is the pin level after a two-flop synchronizer. For an output pin, or a pin that has been taken over, the bit is the latched data.
- R5: Bit 3 at address 0x61 selects the LCD signals. While it is 1, pins 10 and 11 are outputs carrying `lcd_cl` and `lcd_fr` with no pull-up. Their group registers stay readable and writable but have no effect on those pins.
- R6: Bit 0 at address 0x70 enables the serial interface. In slave mode (`sif_is_master` = 0), pin 4 is an input, pin 5 outputs `sif_sout`, pin 6 is an input and pin 7 outputs `sif_rdy`. Pins 4 and 6 keep the pull-up given by their pull-up bit and PU_MASK.
- R7: With serial enabled in master mode, pin 4 is a pull-up-controlled input, pin 5 outputs `sif_sout` and pin 6 outputs `sif_sclk`. Pin 7 stays an ordinary pin.
- R8: A read of address 0x70 returns {0, 0, `sif_busy`, serial enable}. A write to 0x70 with bit 1 set raises `sif_start` for exactly the following cycle. No other event raises it.
- R9: Any address other than the eleven listed above reads as 0, and a write to it changes no register and no pin output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Register address |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | PW | Write data |
| bus_rdata | output | PW | Registered read data for the previous cycle's address |
| pin_in | input | NPIN | Pad input levels (asynchronous) |
| pin_oe | output | NPIN | Per-pin output enable |
| pin_out | output | NPIN | Per-pin output value |
| pin_pu | output | NPIN | Per-pin pull-up enable |
| sif_is_master | input | 1 | Serial mode from the serial block, 1 = master |
| sif_busy | input | 1 | Serial busy status |
| sif_sout | input | 1 | Serial data output from the serial block |
| sif_sclk | input | 1 | Serial clock output (master mode) |
| sif_rdy | input | 1 | Serial ready output (slave mode) |
| sif_start | output | 1 | One-cycle serial start pulse |
| lcd_cl | input | 1 | LCD sync clock from the LCD driver |
| lcd_fr | input | 1 | LCD frame signal from the LCD driver |

## Verification
The assertions check four things on every cycle. Pull-up and output enable are never both active on a pin. No pin without a fitted pull-up ever gets one. The start pulse appears only after a trigger write. While the select bits are set, the LCD and serial overrides hold the expected pin directions and values. Other behaviour shows only in the bench's scenarios, because each depends on a history of writes: read data that mixes pin levels with latched bits, group registers that keep their stored values while inert, and unmapped writes that change nothing.

// File: rtl/gpio_altfn_pkg.sv
package gpio_altfn_pkg;
  // Who owns a pin this cycle
  typedef enum logic [1:0] {
    ROLE_GPIO    = 2'd0,
    ROLE_ALT_OUT = 2'd1,
    ROLE_ALT_IN  = 2'd2
  } pin_role_e;

  // Register offsets inside one pin group
  localparam int OFS_DIR = 0;
  localparam int OFS_PUL = 1;
  localparam int OFS_DAT = 2;

  // Bit positions in the select registers
  localparam int LCD_SEL_BIT  = 3;
  localparam int SIF_EN_BIT   = 0;
  localparam int SIF_TRIG_BIT = 1;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_dir,
  input  logic          we_pul,
  input  logic          we_dat,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] dir_q,
  output logic [PW-1:0] pul_q,
  output logic [PW-1:0] dat_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      pul_q <= '1;
      dat_q <= '0;
    end else begin
      if (we_dir) dir_q <= wdata;
      if (we_pul) pul_q <= wdata;
      if (we_dat) dat_q <= wdata;
    end
  end
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_pin_role.sv
module gpio_pin_role
  import gpio_altfn_pkg::*;
#(
  parameter int NPORT    = 3,
  parameter int PW       = 4,
  parameter int SIF_PORT = 1,
  parameter int LCD_PORT = 2,
  localparam int NPIN    = NPORT * PW
) (
  input  logic                   sif_en,
  input  logic                   sif_is_master,
  input  logic                   lcd_sel,
  output pin_role_e [NPIN-1:0]   role
);
  localparam int S = SIF_PORT * PW;
  localparam int L = LCD_PORT * PW;

  always_comb begin
    for (int i = 0; i < NPIN; i++) role[i] = ROLE_GPIO;
    if (sif_en) begin
      role[S+0] = ROLE_ALT_IN;                               // serial data in
      role[S+1] = ROLE_ALT_OUT;                              // serial data out
      role[S+2] = sif_is_master ? ROLE_ALT_OUT : ROLE_ALT_IN; // clock
      if (!sif_is_master) role[S+3] = ROLE_ALT_OUT;          // ready (slave only)
    end
    if (lcd_sel) begin
      role[L+2] = ROLE_ALT_OUT;
      role[L+3] = ROLE_ALT_OUT;
    end
  end
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
  import gpio_altfn_pkg::*;
#(
  parameter int              NPIN    = 12,
  parameter logic [NPIN-1:0] PU_MASK = '1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  pin_role_e [NPIN-1:0] role,
  input  logic [NPIN-1:0]      dir,
  input  logic [NPIN-1:0]      pul,
  input  logic [NPIN-1:0]      dat,
  input  logic [NPIN-1:0]      alt_val,
  output logic [NPIN-1:0]      oe,
  output logic [NPIN-1:0]      out,
  output logic [NPIN-1:0]      pu
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        oe[i]  <= 1'b0;
        out[i] <= 1'b0;
        pu[i]  <= PU_MASK[i];
      end else begin
        unique case (role[i])
          ROLE_GPIO: begin
            oe[i]  <= dir[i];
            out[i] <= dat[i];
            pu[i]  <= ~dir[i] & pul[i] & PU_MASK[i];
          end
          ROLE_ALT_OUT: begin
            oe[i]  <= 1'b1;
            out[i] <= alt_val[i];
            pu[i]  <= 1'b0;
          end
          ROLE_ALT_IN: begin
            oe[i]  <= 1'b0;
            out[i] <= 1'b0;
            pu[i]  <= pul[i] & PU_MASK[i];
          end
          default: begin
            oe[i]  <= 1'b0;
            out[i] <= 1'b0;
            pu[i]  <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_altfn_ctrl.sv
module gpio_altfn_ctrl
  import gpio_altfn_pkg::*;
#(
  parameter int               NPORT       = 3,
  parameter int               PW          = 4,
  parameter int               AW          = 8,
  parameter logic [AW-1:0]    PORT_BASE   = 8'h40,
  parameter int               PORT_STRIDE = 4,
  parameter logic [AW-1:0]    LCD_ADDR    = 8'h61,
  parameter logic [AW-1:0]    SIF_ADDR    = 8'h70,
  parameter logic [NPORT*PW-1:0] PU_MASK  = '1,
  localparam int              NPIN        = NPORT * PW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [PW-1:0]   bus_wdata,
  output logic [PW-1:0]   bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_oe,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_pu,
  input  logic            sif_is_master,
  input  logic            sif_busy,
  input  logic            sif_sout,
  input  logic            sif_sclk,
  input  logic            sif_rdy,
  output logic            sif_start,
  input  logic            lcd_cl,
  input  logic            lcd_fr
);
  localparam int SIF_PORT = 1;
  localparam int LCD_PORT = 2;
  localparam int S        = SIF_PORT * PW;
  localparam int L        = LCD_PORT * PW;

  function automatic logic [AW-1:0] reg_addr(int p, int k);
    return AW'(int'(PORT_BASE) + p * PORT_STRIDE + k);
  endfunction

  logic [NPIN-1:0]       dir_all, pul_all, dat_all, pin_sync, dat_view, alt_val;
  pin_role_e [NPIN-1:0]  role;
  logic                  lcd_sel_q, sif_en_q, sif_start_q;
  logic [PW-1:0]         rd_next, rdata_q;
  logic                  lcd_wr, sif_wr;

  assign lcd_wr = bus_we && (bus_addr == LCD_ADDR);
  assign sif_wr = bus_we && (bus_addr == SIF_ADDR);

  // R2: one register group per port
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    gpio_port_regs #(.PW(PW)) u_regs (
      .clk    (clk),
      .rst    (rst),
      .we_dir (bus_we && bus_addr == reg_addr(p, OFS_DIR)),
      .we_pul (bus_we && bus_addr == reg_addr(p, OFS_PUL)),
      .we_dat (bus_we && bus_addr == reg_addr(p, OFS_DAT)),
      .wdata  (bus_wdata),
      .dir_q  (dir_all[p*PW +: PW]),
      .pul_q  (pul_all[p*PW +: PW]),
      .dat_q  (dat_all[p*PW +: PW])
    );
  end

  // Function-select and trigger registers (R5, R6, R8)
  always_ff @(posedge clk) begin
    if (rst) begin
      lcd_sel_q   <= 1'b0;
      sif_en_q    <= 1'b0;
      sif_start_q <= 1'b0;
      rdata_q     <= '0;
    end else begin
      if (lcd_wr) lcd_sel_q <= bus_wdata[LCD_SEL_BIT];
      if (sif_wr) sif_en_q  <= bus_wdata[SIF_EN_BIT];
      sif_start_q <= sif_wr && bus_wdata[SIF_TRIG_BIT];
      rdata_q     <= rd_next;
    end
  end

  gpio_sync2 #(.W(NPIN)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  gpio_pin_role #(.NPORT(NPORT), .PW(PW), .SIF_PORT(SIF_PORT), .LCD_PORT(LCD_PORT)) u_role (
    .sif_en        (sif_en_q),
    .sif_is_master (sif_is_master),
    .lcd_sel       (lcd_sel_q),
    .role          (role)
  );

  always_comb begin
    alt_val        = '0;
    alt_val[S+1]   = sif_sout;
    alt_val[S+2]   = sif_sclk;
    alt_val[S+3]   = sif_rdy;
    alt_val[L+2]   = lcd_cl;
    alt_val[L+3]   = lcd_fr;
  end

  gpio_pin_drive #(.NPIN(NPIN), .PU_MASK(PU_MASK)) u_drive (
    .clk     (clk),
    .rst     (rst),
    .role    (role),
    .dir     (dir_all),
    .pul     (pul_all),
    .dat     (dat_all),
    .alt_val (alt_val),
    .oe      (pin_oe),
    .out     (pin_out),
    .pu      (pin_pu)
  );

  // R4: input pins read their level, all others read the latch
  always_comb begin
    for (int i = 0; i < NPIN; i++)
      dat_view[i] = (role[i] == ROLE_GPIO && !dir_all[i]) ? pin_sync[i] : dat_all[i];
  end

  // Read mux, R9: unmatched addresses give zero
  always_comb begin
    rd_next = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (bus_addr == reg_addr(p, OFS_DIR)) rd_next = dir_all[p*PW +: PW];
      if (bus_addr == reg_addr(p, OFS_PUL)) rd_next = pul_all[p*PW +: PW];
      if (bus_addr == reg_addr(p, OFS_DAT)) rd_next = dat_view[p*PW +: PW];
    end
    if (bus_addr == LCD_ADDR) rd_next[LCD_SEL_BIT] = lcd_sel_q;
    if (bus_addr == SIF_ADDR) begin
      rd_next[SIF_EN_BIT]   = sif_en_q;
      rd_next[SIF_TRIG_BIT] = sif_busy;
    end
  end

  assign bus_rdata = rdata_q;
  assign sif_start = sif_start_q;
endmodule

// File: rtl/gpio_altfn_ctrl_chk.sv
module gpio_altfn_ctrl_chk #(
  parameter int              NPIN    = 12,
  parameter int              AW      = 8,
  parameter int              S       = 4,
  parameter int              L       = 8,
  parameter logic [AW-1:0]   SIF_ADDR = 8'h70,
  parameter logic [NPIN-1:0] PU_MASK = '1
) (
  input logic            clk,
  input logic            rst,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_we,
  input logic            wr_trig,
  input logic [NPIN-1:0] pin_oe,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] pin_pu,
  input logic            sif_start,
  input logic            sif_is_master,
  input logic            lcd_cl,
  input logic            lcd_fr,
  input logic            lcd_sel,
  input logic            sif_en
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_out == '0 && pin_pu == PU_MASK && !sif_start));

  a_r3_pu_not_with_oe: assert property (@(posedge clk) disable iff (rst)
    (pin_pu & pin_oe) == '0);

  a_r3_pu_masked: assert property (@(posedge clk) disable iff (rst)
    (pin_pu & ~PU_MASK) == '0);

  a_r8_start_from_write: assert property (@(posedge clk) disable iff (rst)
    sif_start |-> $past(bus_we && bus_addr == SIF_ADDR && wr_trig));

  a_r5_lcd_drive: assert property (@(posedge clk) disable iff (rst)
    lcd_sel |=> (pin_oe[L+2] && pin_oe[L+3] && !pin_pu[L+2] && !pin_pu[L+3] &&
                 pin_out[L+2] == $past(lcd_cl) && pin_out[L+3] == $past(lcd_fr)));

  a_r6_slave_dirs: assert property (@(posedge clk) disable iff (rst)
    (sif_en && !sif_is_master) |=> (!pin_oe[S+0] && pin_oe[S+1] && !pin_oe[S+2] && pin_oe[S+3]));

  a_r7_master_dirs: assert property (@(posedge clk) disable iff (rst)
    (sif_en && sif_is_master) |=> (!pin_oe[S+0] && pin_oe[S+1] && pin_oe[S+2] && !pin_pu[S+2]));
endmodule

bind gpio_altfn_ctrl gpio_altfn_ctrl_chk #(
  .NPIN(NPIN), .AW(AW), .S(S), .L(L), .SIF_ADDR(SIF_ADDR), .PU_MASK(PU_MASK)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .bus_addr      (bus_addr),
  .bus_we        (bus_we),
  .wr_trig       (bus_wdata[1]),
  .pin_oe        (pin_oe),
  .pin_out       (pin_out),
  .pin_pu        (pin_pu),
  .sif_start     (sif_start),
  .sif_is_master (sif_is_master),
  .lcd_cl        (lcd_cl),
  .lcd_fr        (lcd_fr),
  .lcd_sel       (lcd_sel_q),
  .sif_en        (sif_en_q)
);

// File: tb/gpio_altfn_ctrl_tb.sv
module gpio_altfn_ctrl_tb;
  localparam logic [11:0] TB_PU_MASK = 12'hB7F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_wdata = '0;
  logic [3:0]  bus_rdata;
  logic [11:0] pin_in = '0;
  logic [11:0] pin_oe, pin_out, pin_pu;
  logic        sif_is_master = 1'b0, sif_busy = 1'b0;
  logic        sif_sout = 1'b0, sif_sclk = 1'b0, sif_rdy = 1'b0;
  logic        sif_start;
  logic        lcd_cl = 1'b0, lcd_fr = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;

  // Model state
  logic [3:0] m_dir [3];
  logic [3:0] m_pul [3];
  logic [3:0] m_dat [3];
  logic       m_lcd, m_sif;

  always #4 clk = ~clk;

  gpio_altfn_ctrl #(.PU_MASK(TB_PU_MASK)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu),
    .sif_is_master(sif_is_master), .sif_busy(sif_busy), .sif_sout(sif_sout),
    .sif_sclk(sif_sclk), .sif_rdy(sif_rdy), .sif_start(sif_start),
    .lcd_cl(lcd_cl), .lcd_fr(lcd_fr)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    #(8 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // 0 = ordinary, 1 = taken as output, 2 = taken as input (R5, R6, R7)
  function automatic int role_of(int i);
    int g = i / 4;
    int b = i % 4;
    if (g == 1 && m_sif) begin
      if (b == 0) return 2;
      if (b == 1) return 1;
      if (b == 2) return sif_is_master ? 1 : 2;
      return sif_is_master ? 0 : 1;
    end
    if (g == 2 && m_lcd && b >= 2) return 1;
    return 0;
  endfunction

  function automatic logic alt_of(int i);
    case (i)
      5: return sif_sout;
      6: return sif_sclk;
      7: return sif_rdy;
      10: return lcd_cl;
      11: return lcd_fr;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [11:0] e_oe();
    logic [11:0] v;
    for (int i = 0; i < 12; i++)
      v[i] = (role_of(i) == 0) ? m_dir[i/4][i%4] : (role_of(i) == 1);
    return v;
  endfunction

  function automatic logic [11:0] e_out();
    logic [11:0] v;
    for (int i = 0; i < 12; i++)
      v[i] = (role_of(i) == 0) ? m_dat[i/4][i%4] : (role_of(i) == 1 ? alt_of(i) : 1'b0);
    return v;
  endfunction

  function automatic logic [11:0] e_pu();
    logic [11:0] v;
    for (int i = 0; i < 12; i++) begin
      logic pb = m_pul[i/4][i%4] & TB_PU_MASK[i];
      case (role_of(i))
        0: v[i] = pb & ~m_dir[i/4][i%4];
        1: v[i] = 1'b0;
        default: v[i] = pb;
      endcase
    end
    return v;
  endfunction

  function automatic logic [3:0] e_read(logic [7:0] a);
    for (int g = 0; g < 3; g++) begin
      if (a == 8'h40 + 8'(4*g)) return m_dir[g];
      if (a == 8'h41 + 8'(4*g)) return m_pul[g];
      if (a == 8'h42 + 8'(4*g)) begin
        logic [3:0] v;
        for (int b = 0; b < 4; b++) begin
          int i = 4*g + b;
          v[b] = (role_of(i) == 0 && !m_dir[g][b]) ? pin_in[i] : m_dat[g][b];
        end
        return v;
      end
    end
    if (a == 8'h61) return {m_lcd, 3'b000};
    if (a == 8'h70) return {2'b00, sif_busy, m_sif};
    return 4'h0;
  endfunction

  function automatic logic [7:0] pick_addr(int k);
    case (k)
      0: return 8'h40;  1: return 8'h41;  2: return 8'h42;
      3: return 8'h44;  4: return 8'h45;  5: return 8'h46;
      6: return 8'h48;  7: return 8'h49;  8: return 8'h4A;
      9: return 8'h61;  10: return 8'h70; 11: return 8'h43;
      12: return 8'h4B; default: return 8'h50;
    endcase
  endfunction

  // Bus write; also checks the start pulse (R8)
  task automatic do_write(logic [7:0] a, logic [3:0] d);
    logic trig = (a == 8'h70) && d[1];
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    for (int g = 0; g < 3; g++) begin
      if (a == 8'h40 + 8'(4*g)) m_dir[g] = d;
      if (a == 8'h41 + 8'(4*g)) m_pul[g] = d;
      if (a == 8'h42 + 8'(4*g)) m_dat[g] = d;
    end
    if (a == 8'h61) m_lcd = d[3];
    if (a == 8'h70) m_sif = d[0];
    chk("R8", "sif_start after write", 32'(sif_start), 32'(trig));
    @(negedge clk);
    chk("R8", "sif_start one cycle later", 32'(sif_start), 32'd0);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic check_pins(string tag);
    chk(tag, "pin_oe", 32'(pin_oe), 32'(e_oe()));
    chk(tag, "pin_out", 32'(pin_out), 32'(e_out()));
    chk(tag, "pin_pu", 32'(pin_pu), 32'(e_pu()));
  endtask

  task automatic check_read(logic [7:0] a, string tag);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    chk(tag, $sformatf("read %h", a), 32'(bus_rdata), 32'(e_read(a)));
  endtask

  task automatic read_all(string tag);
    for (int k = 0; k < 14; k++) check_read(pick_addr(k), tag);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int g = 0; g < 3; g++) begin
      m_dir[g] = 4'h0; m_pul[g] = 4'hF; m_dat[g] = 4'h0;
    end
    m_lcd = 1'b0; m_sif = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state at pins and in every register
    check_pins("R1");
    read_all("R1");

    // R2/R3: direction, data and pull-up on ordinary pins
    do_write(8'h40, 4'b1010);
    do_write(8'h42, 4'b0110);
    do_write(8'h45, 4'b0101);
    settle();
    check_pins("R2");
    check_pins("R3");

    // R4: mixed read of pin levels and latched bits
    pin_in = 12'hA5C;
    settle();
    check_read(8'h42, "R4");
    check_read(8'h46, "R4");

    // R5: LCD takeover; writes to pins 10,11 registers stay stored but inert
    lcd_cl = 1'b1; lcd_fr = 1'b0;
    do_write(8'h48, 4'b0011);
    do_write(8'h4A, 4'b1110);
    do_write(8'h61, 4'b1000);
    settle();
    check_pins("R5");
    check_read(8'h48, "R5");
    check_read(8'h4A, "R5");
    check_read(8'h61, "R5");

    // R6: serial slave mode
    sif_is_master = 1'b0; sif_sout = 1'b1; sif_rdy = 1'b1;
    do_write(8'h44, 4'b0000);
    do_write(8'h45, 4'b1111);
    do_write(8'h70, 4'b0001);
    settle();
    check_pins("R6");

    // R7: master mode, pin 7 stays ordinary
    sif_is_master = 1'b1; sif_sclk = 1'b1;
    do_write(8'h44, 4'b1000);
    do_write(8'h46, 4'b1000);
    settle();
    check_pins("R7");

    // R8: trigger pulse and busy readback
    sif_busy = 1'b1;
    do_write(8'h70, 4'b0011);
    check_read(8'h70, "R8");

    // R9: unmapped write changes nothing
    do_write(8'h43, 4'hF);
    do_write(8'h50, 4'hF);
    settle();
    check_pins("R9");
    read_all("R9");

    // Constrained random mix
    for (int it = 0; it < 300; it++) begin
      pin_in        = 12'($urandom);
      sif_is_master = 1'($urandom);
      sif_busy      = 1'($urandom);
      sif_sout      = 1'($urandom);
      sif_sclk      = 1'($urandom);
      sif_rdy       = 1'($urandom);
      lcd_cl        = 1'($urandom);
      lcd_fr        = 1'($urandom);
      do_write(pick_addr(int'($urandom_range(0, 13))), 4'($urandom));
      settle();
      check_pins("random");
      check_read(pick_addr(int'($urandom_range(0, 13))), "random");
    end

    summary();
    $finish;
  end
endmodule